// File: doc/BRIEF.md
# Pipelined Byte Histogram Engine

The engine counts how often each of the 256 possible byte values occurs in a file stream. The resulting byte-frequency profile acts as a cheap fingerprint of the file, which can be compared with the expected profile for its claimed type at ingest time. Input arrives as words of four bytes with a valid/ready handshake, and one word is taken every clock. Each byte lane owns a private sub-histogram memory, so the four lanes never compete for a memory port. Inside each lane a short forwarding path keeps back-to-back hits on the same bin from losing counts.

When the beat flagged as the end of the stream has been accepted, the engine stops taking input and waits for the lane pipelines to empty. It then walks the bins in ascending order, adds the four lane counts for each bin, and streams out one (bin, count) pair per clock. A one-cycle done pulse follows the last pair. Counts build up across streams until a clear command is given. A clear zeroes every bin over 256 cycles, and a clear also runs automatically after reset.

Top module: `byte_hist_engine`

## Requirements
- R1: After reset the input ready signal stays low for exactly 256 clock cycles while the banks are zeroed, then goes high. The output valid and done signals stay low during this time.
- R2: On every clock where in_valid and in_ready are both high, the beat is accepted. Byte lane i is in_data[8i+7:8i], and each accepted lane adds one to the bin selected by its byte value.
- R3: A lane whose in_be bit is 0 (bit i enables lane i) is not counted for that beat.
- R4: Updates to the same bin in consecutive beats, whether in the same lane or in different lanes, lose no counts.
- R5: Each lane's count for a bin saturates at the largest value of the count width, and the merged per-bin sum also saturates at that value.
- R6: An accepted beat with in_last high drops in_ready from the next cycle onward. The first output pair appears on the fourth clock after the accepting edge. The pairs cover bins 0 to 255 in ascending order on consecutive cycles, and in_ready stays low while they stream.
- R7: merge_done is high for exactly one cycle, in the cycle just after the pair for bin 255. in_ready is high again in that same cycle.
- R8: Each merged count equals the number of counted bytes with that value since the last clear, summed over all streams.
- R9: A clear_req seen while in_ready is high drops in_ready for 258 cycles (2 cycles of drain, then 256 cycles of zeroing). A beat accepted in the same cycle as the clear is discarded, and every bin reads zero afterwards.
- R10: A clear_req given while in_ready is low has no effect, and the counts are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Engine accepts a beat this cycle |
| in_data | input | 32 | Four bytes; lane i in bits 8i+7:8i |
| in_be | input | 4 | Per-lane byte enable |
| in_last | input | 1 | Beat is the last of the stream |
| clear_req | input | 1 | Zero all bins (honoured only while ready) |
| out_valid | output | 1 | Merged pair valid |
| out_bin | output | 8 | Bin index of the pair |
| out_count | output | 32 | Merged, saturated count of the bin |
| merge_done | output | 1 | One-cycle pulse after the last pair |

## Verification
The assertions assume that in_last is only meaningful together with in_valid. They also assume that a new stream is started only after the previous merge has signalled done, because input is refused while a merge runs. The stimulus follows these rules: it drives one stream at a time and waits for merge_done before starting the next. It only raises clear_req outside the merge on purpose, except for one deliberate pulse during a merge that tests R10. The random streams mix idle gaps with dense runs over a two-symbol alphabet, so that same-bin collisions inside the forwarding window happen often.

// File: rtl/byte_hist_pkg.sv
package byte_hist_pkg;
    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_ACTIVE,
        ST_DRAIN,
        ST_MERGE,
        ST_FINISH
    } seq_state_e;
endpackage

// File: rtl/hist_lane.sv
// One byte lane: private count memory with a two-stage read-increment-write
// pipeline. A capture-time bypass forwards the value being written back so
// that consecutive hits on one bin are never lost.
module hist_lane #(
    parameter int BIN_W = 8,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [BIN_W-1:0] upd_bin,
    input  logic             clr_en,
    input  logic [BIN_W-1:0] clr_bin,
    input  logic [BIN_W-1:0] rd_bin,
    output logic [CNT_W-1:0] rd_cnt
);
    localparam int NBINS = 1 << BIN_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             s1_vld;
        logic [BIN_W-1:0] s1_bin;
        logic             s2_vld;
        logic [BIN_W-1:0] s2_bin;
        logic [CNT_W-1:0] s2_cnt;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic [CNT_W-1:0] bank [NBINS];
    logic [CNT_W-1:0] inc_cnt;

    always_comb begin
        inc_cnt = (pipe_q.s2_cnt == CNT_MAX) ? CNT_MAX : pipe_q.s2_cnt + 1'b1;
        pipe_d        = pipe_q;
        pipe_d.s1_vld = upd_en;
        pipe_d.s1_bin = upd_bin;
        pipe_d.s2_vld = pipe_q.s1_vld;
        pipe_d.s2_bin = pipe_q.s1_bin;
        if (pipe_q.s2_vld && (pipe_q.s2_bin == pipe_q.s1_bin))
            pipe_d.s2_cnt = inc_cnt;
        else
            pipe_d.s2_cnt = bank[pipe_q.s1_bin];
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    always_ff @(posedge clk) begin
        if (clr_en)
            bank[clr_bin] <= '0;
        else if (pipe_q.s2_vld)
            bank[pipe_q.s2_bin] <= inc_cnt;
    end

    assign rd_cnt = bank[rd_bin];
endmodule

// File: rtl/hist_seq.sv
// Phase sequencer: zeroing walk, accepting, pipeline drain, merge walk, done.
module hist_seq
    import byte_hist_pkg::*;
#(
    parameter int BIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             clear_req,
    output logic             in_ready,
    output logic             clr_en,
    output logic             mrg_en,
    output logic [BIN_W-1:0] idx,
    output logic             done
);
    localparam logic [BIN_W-1:0] LAST_IDX = '1;

    typedef struct packed {
        seq_state_e       st;
        logic [BIN_W-1:0] idx;
        logic             drn;
        logic             to_clr;
        logic             done;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_CLEAR, idx: '0, drn: 1'b0, to_clr: 1'b0, done: 1'b0};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            ST_CLEAR: begin
                seq_d.idx = seq_q.idx + 1'b1;
                if (seq_q.idx == LAST_IDX) seq_d.st = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (clear_req) begin
                    seq_d.st     = ST_DRAIN;
                    seq_d.drn    = 1'b0;
                    seq_d.to_clr = 1'b1;
                end else if (in_valid && in_last) begin
                    seq_d.st     = ST_DRAIN;
                    seq_d.drn    = 1'b0;
                    seq_d.to_clr = 1'b0;
                end
            end
            ST_DRAIN: begin
                seq_d.drn = 1'b1;
                if (seq_q.drn) begin
                    seq_d.st  = seq_q.to_clr ? ST_CLEAR : ST_MERGE;
                    seq_d.idx = '0;
                end
            end
            ST_MERGE: begin
                seq_d.idx = seq_q.idx + 1'b1;
                if (seq_q.idx == LAST_IDX) seq_d.st = ST_FINISH;
            end
            ST_FINISH: begin
                seq_d.done = 1'b1;
                seq_d.st   = ST_ACTIVE;
            end
            default: seq_d.st = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= SEQ_RST;
        else     seq_q <= seq_d;
    end

    assign in_ready = (seq_q.st == ST_ACTIVE);
    assign clr_en   = (seq_q.st == ST_CLEAR);
    assign mrg_en   = (seq_q.st == ST_MERGE);
    assign idx      = seq_q.idx;
    assign done     = seq_q.done;
endmodule

// File: rtl/byte_hist_engine.sv
module byte_hist_engine #(
    parameter int LANES = 4,
    parameter int BIN_W = 8,
    parameter int CNT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LANES*BIN_W-1:0] in_data,
    input  logic [LANES-1:0]       in_be,
    input  logic                   in_last,
    input  logic                   clear_req,
    output logic                   out_valid,
    output logic [BIN_W-1:0]       out_bin,
    output logic [CNT_W-1:0]       out_count,
    output logic                   merge_done
);
    localparam int SUM_W = CNT_W + $clog2(LANES) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             clr_en, mrg_en, seq_done;
    logic [BIN_W-1:0] seq_idx;
    logic [CNT_W-1:0] lane_cnt [LANES];

    hist_seq #(.BIN_W(BIN_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_last  (in_last),
        .clear_req(clear_req),
        .in_ready (in_ready),
        .clr_en   (clr_en),
        .mrg_en   (mrg_en),
        .idx      (seq_idx),
        .done     (seq_done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hist_lane #(.BIN_W(BIN_W), .CNT_W(CNT_W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .upd_en (in_valid && in_ready && in_be[g]),
            .upd_bin(in_data[g*BIN_W +: BIN_W]),
            .clr_en (clr_en),
            .clr_bin(seq_idx),
            .rd_bin (seq_idx),
            .rd_cnt (lane_cnt[g])
        );
    end

    typedef struct packed {
        logic             vld;
        logic [BIN_W-1:0] bin;
        logic [CNT_W-1:0] cnt;
    } out_t;

    out_t out_d, out_q;
    logic [SUM_W-1:0] bin_sum;

    always_comb begin
        bin_sum = '0;
        for (int i = 0; i < LANES; i++)
            bin_sum = bin_sum + SUM_W'(lane_cnt[i]);
        out_d.vld = mrg_en;
        out_d.bin = seq_idx;
        out_d.cnt = (bin_sum > SUM_W'(CNT_MAX)) ? CNT_MAX : bin_sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign out_valid  = out_q.vld;
    assign out_bin    = out_q.bin;
    assign out_count  = out_q.cnt;
    assign merge_done = seq_done;
endmodule

// File: rtl/hist_checker.sv
module hist_checker #(
    parameter int BIN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_last,
    input logic             clear_req,
    input logic             out_valid,
    input logic [BIN_W-1:0] out_bin,
    input logic             merge_done
);
    AST_READY_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !in_ready) else $error("ready high right after reset"); // R1

    AST_LAST_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> !in_ready) else $error("ready after last"); // R6

    AST_FIRST_BIN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(out_valid)) |-> (out_bin == '0)) else $error("merge not at bin 0"); // R6

    AST_BIN_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_bin == $past(out_bin) + 1'b1)) else $error("bin order"); // R6

    AST_NO_OUT_WHILE_READY: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !out_valid) else $error("pair while accepting"); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        merge_done |=> !merge_done) else $error("done wider than one cycle"); // R7

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        merge_done |-> ($past(out_valid) && ($past(out_bin) == '1))) else $error("done misplaced"); // R7

    AST_CLEAR_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (clear_req && in_ready) |=> !in_ready) else $error("ready during clear"); // R9
endmodule

bind byte_hist_engine hist_checker #(.BIN_W(BIN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .clear_req (clear_req),
    .out_valid (out_valid),
    .out_bin   (out_bin),
    .merge_done(merge_done)
);

// File: tb/byte_hist_engine_test.sv
module byte_hist_engine_test;
    localparam int LANES = 4;
    localparam int BW    = 8;
    localparam int CW    = 8;
    localparam int NB    = 256;
    localparam int CMAX  = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [31:0]     in_data = '0;
    logic [3:0]      in_be = '0;
    logic            in_last = 1'b0;
    logic            clear_req = 1'b0;
    logic            out_valid;
    logic [BW-1:0]   out_bin;
    logic [CW-1:0]   out_count;
    logic            merge_done;

    int vectors = 0;
    int errors  = 0;
    int ref_lane [LANES][NB];

    byte_hist_engine #(.LANES(LANES), .BIN_W(BW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_be(in_be), .in_last(in_last), .clear_req(clear_req),
        .out_valid(out_valid), .out_bin(out_bin), .out_count(out_count),
        .merge_done(merge_done)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        report();
    end

    function automatic int exp_bin(input int b);
        int s = 0;
        for (int l = 0; l < LANES; l++) s += ref_lane[l][b];
        return (s > CMAX) ? CMAX : s;
    endfunction

    function automatic void ref_clear();
        for (int l = 0; l < LANES; l++)
            for (int b = 0; b < NB; b++) ref_lane[l][b] = 0;
    endfunction

    function automatic void ref_add(input logic [31:0] d, input logic [3:0] be);
        for (int l = 0; l < LANES; l++)
            if (be[l] && ref_lane[l][d[l*8 +: 8]] < CMAX)
                ref_lane[l][d[l*8 +: 8]]++;
    endfunction

    // mode 0: random bytes with gaps; 1: constant byte all lanes; 2: lane 0 only;
    // 3: two-symbol alphabet, random enables, no gaps; 4: all enables off
    task automatic send_stream(input int nbeats, input int mode, input bit clr_mid,
                               input string req);
        int sent = 0;
        int n = 0;
        int k = 0;
        bit seen_done = 0;
        bit prev255 = 0;
        while (sent < nbeats) begin
            @(negedge clk);
            in_valid = (mode == 0) ? ($urandom % 4 != 0) : 1'b1;
            in_last  = (sent == nbeats - 1);
            case (mode)
                0: begin in_data = $urandom; in_be = in_last ? 4'($urandom) : 4'hF; end
                1: begin in_data = 32'h41414141; in_be = 4'hF; end
                2: begin in_data = {24'($urandom), 8'h7E}; in_be = 4'h1; end
                3: begin
                    for (int l = 0; l < LANES; l++)
                        in_data[l*8 +: 8] = ($urandom % 2) ? 8'h20 : 8'h65;
                    in_be = 4'($urandom);
                end
                default: begin in_data = $urandom; in_be = 4'h0; end
            endcase
            if (in_valid && in_ready) begin
                ref_add(in_data, in_be);
                sent++;
            end
        end
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin in_valid = 1'b0; in_last = 1'b0; end
            clear_req = 1'b0;
            if (merge_done) begin
                check(k == NB && prev255, "R7", "done after last pair", k, NB);
                check(in_ready, "R7", "ready back with done", in_ready, 1);
                seen_done = 1;
            end else begin
                check(!in_ready, "R6", "ready low during merge", in_ready, 0);
            end
            prev255 = 0;
            if (out_valid) begin
                if (k == 0) check(n == 4, "R6", "first pair latency", n, 4);
                check(out_bin == BW'(k), "R6", "bin order", out_bin, k);
                check(out_count == CW'(exp_bin(k)), req, "merged count", out_count, exp_bin(k));
                prev255 = (out_bin == 8'hFF);
                k++;
                if (clr_mid && k == 100) clear_req = 1'b1;
            end
        end while (!seen_done && n < 2000);
        @(negedge clk);
        check(!merge_done, "R7", "done is one cycle", merge_done, 0);
    endtask

    task automatic do_clear(input bit with_beat);
        int n = 1;
        @(negedge clk);
        check(in_ready, "R9", "ready before clear", in_ready, 1);
        clear_req = 1'b1;
        in_valid  = with_beat;
        in_data   = 32'h30313233;
        in_be     = 4'hF;
        in_last   = 1'b0;
        @(negedge clk);
        clear_req = 1'b0;
        in_valid  = 1'b0;
        while (!in_ready && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(n == 259, "R9", "clear busy length", n, 259);
        ref_clear();
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        ref_clear();
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 1; i <= 255; i++) begin
            @(negedge clk);
            if (i == 1 || i == 255) begin
                check(!in_ready, "R1", "ready low while zeroing", in_ready, 0);
                check(!out_valid && !merge_done, "R1", "outputs idle", out_valid, 0);
            end
        end
        @(negedge clk);
        check(in_ready, "R1", "ready after 256 cycles", in_ready, 1);

        send_stream(3, 4, 0, "R3");
        send_stream(60, 0, 0, "R2");
        send_stream(20, 1, 1, "R8");
        send_stream(40, 3, 0, "R10");
        do_clear(1);
        send_stream(1, 4, 0, "R9");
        send_stream(300, 2, 0, "R5");
        do_clear(0);
        send_stream(120, 3, 0, "R4");
        send_stream(80, 0, 0, "R2");
        report();
    end
endmodule